// File: doc/BRIEF.md
# Masked-Write GPIO Port Bank

This block is the register bank for one group of general-purpose pins. The pins are split into ports of eight, and four ports make one bank. A simple 32-bit register bus reaches the bank. For each port there are three writable registers: a function-select register, a drive-enable register and an output-level register. A fourth read-only register holds the pad levels after they pass through a two-flop synchroniser. The block drives the pad output level, the pad drive enable and a per-pin function-select line straight from these registers.

Each writable register can also be reached at a second address. A write there carries an update mask in the upper byte of the low half-word and the new pin levels in the lower byte. Only the pins whose mask bit is set take the new level, so software can change one pin without first reading the register. The bank decodes an 8-bit byte offset inside its 0x100-byte window. Address bits 7:4 pick the register, bits 3:2 pick the port, and bits 1:0 are ignored. Pin index p*8+b is bit b of port p.

Top module: `gpio_masked_bank`

## Requirements
- R1: While reset is low, and after it, every register and every output is 0: `pad_out`, `pad_oe`, `pad_gpio_sel`, `bus_rdata` and `bus_rvalid`. Every pin therefore starts as a non-driving input.
- R2: A write to offset 0x00 (function select), 0x10 (drive enable) or 0x20 (output level) plus 4*port replaces all 8 bits of that port's register with `bus_wdata[7:0]`. Data bits 31:8 are ignored. The new value appears on the pad outputs after the clock edge that takes the write.
- R3: A write to alias offset 0x80, 0x90 or 0xA0 plus 4*port updates the matching register. Bit b takes `bus_wdata[b]` where `bus_wdata[8+b]` is 1 and keeps its old value where it is 0. A mask of 0x00 changes nothing.
- R4: For pin i, `pad_oe[i]`=1 means the pin is driven, and 0 means it is an input. `pad_out[i]` always shows the output-level register bit, whatever the enable is. `pad_gpio_sel[i]` shows the function-select bit.
- R5: A read of offset 0x30+4*port returns the synchronised pad levels. A read issued in the cycle after edge E returns the `pad_in` value sampled at edge E-1, which is two flops deep.
- R6: Writes to the input offset 0x30-0x3C, or to any offset whose bits 7:4 are not 0, 1, 2, 3, 8, 9 or A, change no register and no output.
- R7: A read request (`bus_sel`=1, `bus_wr`=0) gives `bus_rvalid`=1 and the data on `bus_rdata` one cycle later. The port byte sits in bits 7:0 and bits 31:8 are 0. An alias offset reads back its plain register. An unmapped offset reads 0. When no read was requested, `bus_rvalid` and `bus_rdata` are 0.
- R8: Address bits 1:0 do not affect decoding. For example, 0x13 reaches the drive-enable register of port 0, and 0x9F reaches the drive-enable alias of port 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset inside the bank window |
| bus_wdata | input | 32 | Write data (masked format for aliases) |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad drive enables (1 = output) |
| pad_gpio_sel | output | 32 | Per-pin function select |

## Verification
The hardest case to reach is a masked write that lands on a register whose bits are mixed ones and zeros. It must carry a mask that keeps some of those bits and rewrites others with both polarities, so that a faulty merge (one that clears or sets the held bits) can be seen on the pads. The stimulus first loads distinct patterns through the plain addresses, then sends masks of 0x00, 0xFF, single bits and nibble patterns, and then runs a long random mix of plain, alias, input, unmapped and misaligned accesses. A reference model checks the pads and the read data every cycle. The synchroniser depth is checked by reading the input register on the cycles right after a pad change.

// File: rtl/gpio_bank_pkg.sv
// Package: shared register-group codes and address nibbles for the GPIO bank.
// Assumes a byte offset whose bits 7:4 select the register group.
package gpio_bank_pkg;

    typedef enum logic [2:0] {
        GRP_NONE = 3'd0,
        GRP_CFG  = 3'd1,
        GRP_OE   = 3'd2,
        GRP_OUT  = 3'd3,
        GRP_IN   = 3'd4
    } grp_e;

    localparam logic [3:0] NIB_CFG      = 4'h0;
    localparam logic [3:0] NIB_OE       = 4'h1;
    localparam logic [3:0] NIB_OUT      = 4'h2;
    localparam logic [3:0] NIB_IN       = 4'h3;
    localparam logic [3:0] NIB_CFG_MSK  = 4'h8;
    localparam logic [3:0] NIB_OE_MSK   = 4'h9;
    localparam logic [3:0] NIB_OUT_MSK  = 4'hA;

    localparam int NUM_KINDS = 3;

    // Maps a writable register kind index to its group code.
    function automatic grp_e kind_grp(input int k);
        case (k)
            0:       return GRP_CFG;
            1:       return GRP_OE;
            default: return GRP_OUT;
        endcase
    endfunction

endpackage

// File: rtl/gpio_bank_decode.sv
// Address decoder: turns a byte offset into a register group, an alias flag
// and a port index. Assumes at most four ports, with the port in bits 3:2.
// Bits 1:0 are ignored. Unknown groups and ports beyond NUM_PORTS give GRP_NONE.
module gpio_bank_decode
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 8,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output grp_e              grp_o,
    output logic              masked_o,
    output logic [PORT_W-1:0] port_o
);

    logic [1:0] port_raw;
    logic       upper_ok;
    logic       port_ok;

    assign port_raw = addr[3:2];
    assign port_o   = port_raw[PORT_W-1:0];
    assign port_ok  = int'(port_raw) < NUM_PORTS;

    generate
        if (ADDR_W > 8) begin : g_upper
            assign upper_ok = (addr[ADDR_W-1:8] == '0);
        end else begin : g_no_upper
            assign upper_ok = 1'b1;
        end
    endgenerate

    // Group decode from the offset nibble.
    always_comb begin
        grp_o    = GRP_NONE;
        masked_o = 1'b0;
        if (upper_ok && port_ok) begin
            case (addr[7:4])
                NIB_CFG:     grp_o = GRP_CFG;
                NIB_OE:      grp_o = GRP_OE;
                NIB_OUT:     grp_o = GRP_OUT;
                NIB_IN:      grp_o = GRP_IN;
                NIB_CFG_MSK: begin grp_o = GRP_CFG; masked_o = 1'b1; end
                NIB_OE_MSK:  begin grp_o = GRP_OE;  masked_o = 1'b1; end
                NIB_OUT_MSK: begin grp_o = GRP_OUT; masked_o = 1'b1; end
                default:     grp_o = GRP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/gpio_port_reg.sv
// One writable port register of PINS bits. A plain write loads all bits from
// wdata[PINS-1:0]. A masked write updates only the bits whose mask bit
// (wdata[PINS+b]) is set. Assumes plain_we and mask_we are never both high.
module gpio_port_reg #(
    parameter int PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              plain_we,
    input  logic              mask_we,
    input  logic [2*PINS-1:0] wdata,
    output logic [PINS-1:0]   q
);

    logic [PINS-1:0] upd_mask;
    logic [PINS-1:0] upd_val;

    assign upd_mask = wdata[2*PINS-1:PINS];
    assign upd_val  = wdata[PINS-1:0];

    // Register update: reset, whole-byte load, or per-bit merge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (plain_we) begin
            q <= upd_val;
        end else if (mask_we) begin
            q <= (q & ~upd_mask) | (upd_val & upd_mask);
        end
    end

    // R2: a plain write lands in full.
    a_r2_plain_load: assert property (@(posedge clk) disable iff (!rst_n)
        plain_we |=> q == $past(upd_val));

    // R3: masked bits take the new level.
    a_r3_masked_set: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && !plain_we) |=> ((q & $past(upd_mask)) == ($past(upd_val) & $past(upd_mask))));

    // R3: unmasked bits hold.
    a_r3_unmasked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && !plain_we) |=> (((q ^ $past(q)) & ~$past(upd_mask)) == '0));

    // R6: no write enable means no change.
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_we && !plain_we) |=> $stable(q));

endmodule

// File: rtl/gpio_in_sync.sv
// Two-flop synchroniser for the pad inputs. Assumes the pad levels are
// asynchronous to clk and that a two-cycle delay is acceptable to software.
module gpio_in_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage1;
    logic             live_q;

    // Two-stage capture of the pad levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

    // Marks cycles after a reset edge, so that the assertion never looks at pre-reset values.
    always_ff @(posedge clk) begin
        live_q <= rst_n;
    end

    // R5: the second stage follows the first by one cycle.
    a_r5_two_stage: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        q == $past(stage1));

endmodule

// File: rtl/gpio_masked_bank.sv
// Top of the GPIO bank: decodes register accesses, holds the function-select,
// drive-enable and output-level registers for each port, and synchronises the
// pad inputs. Reads return data one cycle after the request.
// Assumes single-cycle bus accesses with no back-pressure.
module gpio_masked_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PINS      = 8,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic                        bus_rvalid,
    input  logic [NUM_PORTS*PINS-1:0]   pad_in,
    output logic [NUM_PORTS*PINS-1:0]   pad_out,
    output logic [NUM_PORTS*PINS-1:0]   pad_oe,
    output logic [NUM_PORTS*PINS-1:0]   pad_gpio_sel
);

    localparam int NPINS  = NUM_PORTS * PINS;
    localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    grp_e              dec_grp;
    logic              dec_masked;
    logic [PORT_W-1:0] dec_port;
    logic              wr_req;
    logic              rd_req;
    logic [PINS-1:0]   reg_q [NUM_KINDS][NUM_PORTS];
    logic [NPINS-1:0]  in_sync;
    logic [DATA_W-1:0] rd_word;

    assign wr_req = bus_sel && bus_wr;
    assign rd_req = bus_sel && !bus_wr;

    gpio_bank_decode #(
        .NUM_PORTS (NUM_PORTS),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .addr     (bus_addr),
        .grp_o    (dec_grp),
        .masked_o (dec_masked),
        .port_o   (dec_port)
    );

    gpio_in_sync #(
        .WIDTH (NPINS)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (in_sync)
    );

    // One register per writable kind per port.
    generate
        for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
            for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
                logic hit;
                assign hit = wr_req && (dec_grp == kind_grp(k)) && (int'(dec_port) == p);
                gpio_port_reg #(
                    .PINS (PINS)
                ) u_reg (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .plain_we (hit && !dec_masked),
                    .mask_we  (hit && dec_masked),
                    .wdata    (bus_wdata[2*PINS-1:0]),
                    .q        (reg_q[k][p])
                );
            end
        end
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pads
            assign pad_gpio_sel[p*PINS +: PINS] = reg_q[0][p];
            assign pad_oe[p*PINS +: PINS]       = reg_q[1][p];
            assign pad_out[p*PINS +: PINS]      = reg_q[2][p];
        end
    endgenerate

    // Read mux: picks the addressed port byte and zero-extends it.
    always_comb begin
        rd_word = '0;
        case (dec_grp)
            GRP_CFG: rd_word[PINS-1:0] = reg_q[0][dec_port];
            GRP_OE:  rd_word[PINS-1:0] = reg_q[1][dec_port];
            GRP_OUT: rd_word[PINS-1:0] = reg_q[2][dec_port];
            GRP_IN:  rd_word[PINS-1:0] = in_sync[dec_port*PINS +: PINS];
            default: rd_word = '0;
        endcase
    end

    // Read response register: data and valid one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd_req;
            bus_rdata  <= rd_req ? rd_word : '0;
        end
    end

    // R6: writes to the input register leave every output unchanged.
    a_r6_input_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && dec_grp == GRP_IN) |=> ($stable(pad_out) && $stable(pad_oe) && $stable(pad_gpio_sel)));

    // R7: a read request is answered on the next cycle.
    a_r7_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);

    // R7: unmapped reads return zero.
    a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && dec_grp == GRP_NONE) |=> bus_rdata == '0);

    // R7: upper read bits are always clear.
    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:PINS] == '0);

endmodule

// File: tb/gpio_masked_bank_tb.sv
module gpio_masked_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] pad_in = '0;
    logic [31:0] rdata;
    logic        rvalid;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic [31:0] pad_sel;

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";
    bit    armed = 1'b0;
    bit    done = 1'b0;

    always #10 clk = ~clk;

    gpio_masked_bank u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (sel),
        .bus_wr       (wr),
        .bus_addr     (addr),
        .bus_wdata    (wdata),
        .bus_rdata    (rdata),
        .bus_rvalid   (rvalid),
        .pad_in       (pad_in),
        .pad_out      (pad_out),
        .pad_oe       (pad_oe),
        .pad_gpio_sel (pad_sel)
    );

    // Reference model state
    logic [7:0]  m_cfg [4];
    logic [7:0]  m_oe  [4];
    logic [7:0]  m_out [4];
    logic [31:0] m_s1, m_s2;
    logic [31:0] m_rd;
    logic        m_rv;

    function automatic logic [7:0] merge(input logic [7:0] old, input logic [31:0] d);
        return (old & ~d[15:8]) | (d[7:0] & d[15:8]);
    endfunction

    always @(posedge clk) begin
        int pt;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_cfg[i] = '0; m_oe[i] = '0; m_out[i] = '0;
            end
            m_s1 = '0; m_s2 = '0; m_rd = '0; m_rv = 1'b0;
        end else begin
            pt = int'(addr[3:2]);
            m_rv = sel && !wr;
            m_rd = '0;
            if (sel && !wr) begin
                case (addr[7:4])
                    4'h0, 4'h8: m_rd[7:0] = m_cfg[pt];
                    4'h1, 4'h9: m_rd[7:0] = m_oe[pt];
                    4'h2, 4'hA: m_rd[7:0] = m_out[pt];
                    4'h3:       m_rd[7:0] = m_s2[pt*8 +: 8];
                    default:    m_rd = '0;
                endcase
            end
            if (sel && wr) begin
                case (addr[7:4])
                    4'h0: m_cfg[pt] = wdata[7:0];
                    4'h1: m_oe[pt]  = wdata[7:0];
                    4'h2: m_out[pt] = wdata[7:0];
                    4'h8: m_cfg[pt] = merge(m_cfg[pt], wdata);
                    4'h9: m_oe[pt]  = merge(m_oe[pt], wdata);
                    4'hA: m_out[pt] = merge(m_out[pt], wdata);
                    default: ;
                endcase
            end
            m_s2 = m_s1;
            m_s1 = pad_in;
        end
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare on every falling edge once the model has seen a clock.
    always @(negedge clk) begin
        if (armed && !done) begin
            check("pad_gpio_sel", pad_sel, {m_cfg[3], m_cfg[2], m_cfg[1], m_cfg[0]});
            check("pad_oe",       pad_oe,  {m_oe[3],  m_oe[2],  m_oe[1],  m_oe[0]});
            check("pad_out",      pad_out, {m_out[3], m_out[2], m_out[1], m_out[0]});
            check("bus_rvalid",   {31'b0, rvalid}, {31'b0, m_rv});
            check("bus_rdata",    rdata, m_rd);
        end
    end

    task automatic op(input bit s, input bit w, input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        sel = s; wr = w; addr = a; wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) op(1'b0, 1'b0, 8'h00, 32'h0);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        @(posedge clk); #1;
        armed = 1'b1;
        tag = "R1";
        idle(3);
        @(posedge clk); #1; rst_n = 1'b1;
        idle(2);

        // R2: plain writes, upper data bits must be dropped
        tag = "R2";
        for (int p = 0; p < 4; p++) begin
            op(1, 1, 8'h00 + 8'(p*4), 32'hDEAD_BE00 | 32'(8'h11 * (p+1)));
            op(1, 1, 8'h10 + 8'(p*4), 32'hFFFF_0000 | 32'(8'hC3 ^ p));
            op(1, 1, 8'h20 + 8'(p*4), 32'h5A5A_FF00 | 32'(8'h3C + p));
        end
        tag = "R7";
        for (int p = 0; p < 4; p++) begin
            op(1, 0, 8'h00 + 8'(p*4), 32'h0);
            op(1, 0, 8'h90 + 8'(p*4), 32'h0);
            op(1, 0, 8'hA0 + 8'(p*4), 32'h0);
        end
        op(1, 0, 8'h40, 0); op(1, 0, 8'hB4, 0); op(1, 0, 8'hFC, 0);

        // R4: drive enable and output level per pin
        tag = "R4";
        op(1, 1, 8'h14, 32'h0000_00F0);
        op(1, 1, 8'h24, 32'h0000_0055);
        op(1, 1, 8'h1C, 32'h0000_0000);
        op(1, 1, 8'h2C, 32'h0000_00FF);
        idle(1);

        // R3: masked writes with mixed existing bits
        tag = "R3";
        op(1, 1, 8'hA4, 32'h0000_0000);
        op(1, 1, 8'hA4, 32'h0000_FFA5);
        op(1, 1, 8'hA4, 32'h0000_0F00);
        op(1, 1, 8'hA4, 32'h0000_F00F);
        op(1, 1, 8'h90, 32'h0000_0101);
        op(1, 1, 8'h90, 32'h0000_8000);
        op(1, 1, 8'h8C, 32'hFFFF_3CC3);
        op(1, 1, 8'h88, 32'h0000_2020);
        op(1, 0, 8'hA4, 0); op(1, 0, 8'h90, 0); op(1, 0, 8'h8C, 0);

        // R5: input sync depth
        tag = "R5";
        @(posedge clk); #1; pad_in = 32'hA1B2_C3D4;
        for (int i = 0; i < 4; i++) op(1, 0, 8'h30 + 8'(4*(i%4)), 0);
        @(posedge clk); #1; pad_in = 32'h0F0F_F0F0; sel = 1; wr = 0; addr = 8'h34;
        for (int i = 0; i < 3; i++) op(1, 0, 8'h34, 0);

        // R6: writes to the input and unmapped offsets
        tag = "R6";
        op(1, 1, 8'h30, 32'hFFFF_FFFF);
        op(1, 1, 8'h3C, 32'h0000_FFFF);
        op(1, 1, 8'h40, 32'hFFFF_FFFF);
        op(1, 1, 8'hB0, 32'hFFFF_FFFF);
        op(1, 1, 8'hF8, 32'hFFFF_FFFF);
        op(1, 0, 8'h30, 0);

        // R8: low address bits ignored
        tag = "R8";
        op(1, 1, 8'h13, 32'h0000_0077);
        op(1, 1, 8'h9F, 32'h0000_0F0A);
        op(1, 0, 8'h11, 0);
        op(1, 0, 8'h1E, 0);

        // Random mix of every access type
        tag = "R3";
        for (int i = 0; i < 600; i++) begin
            logic [3:0] nib;
            int c;
            c = int'($urandom_range(0, 9));
            case (c)
                0: nib = 4'h0; 1: nib = 4'h1; 2: nib = 4'h2; 3: nib = 4'h3;
                4: nib = 4'h8; 5: nib = 4'h9; 6: nib = 4'hA; 7: nib = 4'h4;
                8: nib = 4'hB; default: nib = 4'hE;
            endcase
            if ((i % 7) == 0) pad_in = $urandom;
            op(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
               {nib, 4'($urandom)}, $urandom);
        end
        idle(3);

        // R1: reset returns everything to zero
        tag = "R1";
        @(posedge clk); #1; rst_n = 1'b0;
        idle(2);
        @(posedge clk); #1; rst_n = 1'b1;
        idle(2);

        @(negedge clk); #1;
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        done = 1'b1;
        n_cmp++; n_bad++;
        $display("FAIL %s watchdog actual=running expected=finished", tag);
        summary();
        $finish;
    end

endmodule